// File: doc/BRIEF.md
# Flash Status Register Controller

This block keeps the eight-bit primary status register of a serial NOR flash and moves it from state to state in response to command strobes that an upstream SPI front end has already decoded. A command arrives as an opcode byte qualified by `cmd_valid`, with a data byte that only the write-registers opcode uses. Program and erase requests arrive as separate strobes, together with a sector-protected flag that stands in for the address lookup. The program and erase engines send back done pulses, each with a failure flag. The register value is always visible on `status`, so a status read needs no handshake.

Write protection comes from two sources: a write-enable latch that has to be set before any modifying operation, and a hardware lock formed by the protect-lock bit together with the active-low protect pin. The two error bits stay set until the dedicated clear command. While an operation is in progress, every command is dropped, and the request stream has no back-pressure: a strobe that arrives while busy is lost and raises no flag. Write protection and block-protect bits are non-volatile, so they are cleared only by the power-on reset and keep their value across the ordinary reset.

Top module: `flash_status_ctrl`

## Requirements
- R1: Status bit positions are fixed as [7] protect-lock, [6] program error, [5] erase error, [4:2] block-protect 2..0, [1] write-enable latch, [0] busy. After a power-on reset `status` reads 8'h00 with the default non-volatile value.
- R2: With `cmd_valid` high and the block idle, opcode 8'h06 sets the write-enable latch and 8'h04 clears it. Opcode 8'h05 (read status) and any opcode outside {01h, 04h, 05h, 06h, 30h} change nothing and raise no flag.
- R3: Opcode 8'h01 with the latch set is rejected when bit 7 is 1 and `wp_n` is 0. In that case bits 7 and 4:2 keep their value. Otherwise it is accepted, and at commit those bits take `cmd_wdata[7]` and `cmd_wdata[4:2]`.
- R4: The program-error bit sets when a program ends with `op_fail`, or when an enabled program request arrives with `sect_prot` high. Only the clear command returns it to 0.
- R5: The erase-error bit sets when an erase ends with `op_fail`, or when an enabled single-sector erase meets `sect_prot`. A bulk erase (`ers_bulk`=1) that meets `sect_prot` is accepted and does not set it.
- R6: Only 06h sets the write-enable latch. It clears on 04h, on 30h, and when an accepted write-registers, program or erase operation completes. The write-registers data never alters bits 6, 5, 1 or 0.
- R7: With the latch clear, write-registers, program and erase requests raise their reject flag and change no state. At most one accept/reject flag is high in any cycle, one cycle after its request.
- R8: An accepted write-registers operation holds bit 0 high for exactly WRR_CYCLES cycles and commits on the last one. Program and erase hold bit 0 high until their own done pulse.
- R9: While bit 0 is 1, every command and request is ignored and raises no flag.
- R10: Opcode 8'h30 clears the program-error bit, the erase-error bit and the write-enable latch.
- R11: `rst_n` clears bits 6, 5, 1 and 0 but keeps bits 7 and 4:2. `por_n` also restores those bits to NV_DEFAULT.
- R12: Within one cycle, `cmd_valid` takes priority over `pgm_req`, which takes priority over `ers_req`. The lower-priority strobes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears all state |
| rst_n | input | 1 | Hardware/soft reset, active low, keeps non-volatile bits |
| cmd_valid | input | 1 | Decoded opcode present this cycle |
| cmd_op | input | 8 | Opcode byte |
| cmd_wdata | input | 8 | Data byte for write-registers |
| wp_n | input | 1 | Write-protect pin, active low |
| pgm_req | input | 1 | Program request strobe |
| ers_req | input | 1 | Erase request strobe |
| ers_bulk | input | 1 | Erase request covers the whole array |
| sect_prot | input | 1 | Target of the current request is protected or locked |
| pgm_done | input | 1 | Program engine finished |
| ers_done | input | 1 | Erase engine finished |
| op_fail | input | 1 | Qualifies a done pulse as a failure |
| status | output | 8 | Status register value |
| wr_enabled | output | 1 | Write-enable latch qualifier |
| wrr_accept | output | 1 | Write-registers accepted |
| wrr_reject | output | 1 | Write-registers rejected |
| pgm_accept | output | 1 | Program accepted |
| pgm_reject | output | 1 | Program rejected |
| ers_accept | output | 1 | Erase accepted |
| ers_reject | output | 1 | Erase rejected |

## Verification
The assertions take two things for granted. First, both resets are asserted together before the first edge. Second, the inputs carry known values once the resets release. They do not assume that done pulses match an operation in flight, or that only one strobe arrives per cycle. The random stimulus therefore fires done pulses at arbitrary times, overlaps command, program and erase strobes, and toggles `wp_n`, `sect_prot` and `ers_bulk` freely. Only rare, whole-cycle reset pulses are applied, and they are always driven on the falling edge.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRR  = 8'h01;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_CLSR = 8'h30;

  localparam int B_LOCK = 7;
  localparam int B_PERR = 6;
  localparam int B_EERR = 5;
  localparam int B_WEL  = 1;
  localparam int B_WIP  = 0;

  // bits that the write-registers data may reach
  localparam logic [7:0] NV_MASK = 8'b1001_1100;

  typedef enum logic [1:0] {
    BUSY_NONE,
    BUSY_WRR,
    BUSY_PGM,
    BUSY_ERS
  } busy_e;

  typedef enum logic [3:0] {
    ACT_NONE,
    ACT_WREN,
    ACT_WRDI,
    ACT_CLSR,
    ACT_WRR_GO,
    ACT_WRR_REJ,
    ACT_PGM_GO,
    ACT_PGM_REJ,
    ACT_PGM_PROT,
    ACT_ERS_GO,
    ACT_ERS_REJ,
    ACT_ERS_PROT
  } act_e;
endpackage

// File: rtl/fsr_cmd_decode.sv
module fsr_cmd_decode
  import fsr_pkg::*;
(
  input  logic       cmd_valid,
  input  logic [7:0] cmd_op,
  input  logic       pgm_req,
  input  logic       ers_req,
  input  logic       ers_bulk,
  input  logic       sect_prot,
  input  logic       wip,
  input  logic       wel,
  input  logic       lock,
  input  logic       wp_n,
  output act_e       act
);
  logic hw_locked;
  assign hw_locked = lock && !wp_n;

  always_comb begin
    act = ACT_NONE;
    if (!wip) begin
      if (cmd_valid) begin
        case (cmd_op)
          OP_WREN: act = ACT_WREN;
          OP_WRDI: act = ACT_WRDI;
          OP_CLSR: act = ACT_CLSR;
          OP_WRR: begin
            if (!wel || hw_locked) act = ACT_WRR_REJ;
            else                   act = ACT_WRR_GO;
          end
          default: act = ACT_NONE;
        endcase
      end else if (pgm_req) begin
        if (!wel)           act = ACT_PGM_REJ;
        else if (sect_prot) act = ACT_PGM_PROT;
        else                act = ACT_PGM_GO;
      end else if (ers_req) begin
        if (!wel)                       act = ACT_ERS_REJ;
        else if (sect_prot && !ers_bulk) act = ACT_ERS_PROT;
        else                            act = ACT_ERS_GO;
      end
    end
  end
endmodule

// File: rtl/fsr_busy_ctrl.sv
module fsr_busy_ctrl
  import fsr_pkg::*;
#(
  parameter int WRR_CYCLES = 4,
  localparam int CNT_W = (WRR_CYCLES > 1) ? $clog2(WRR_CYCLES) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  act_e act,
  input  logic pgm_done,
  input  logic ers_done,
  output logic wip,
  output logic wrr_commit,
  output logic op_end,
  output logic pgm_end,
  output logic ers_end
);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WRR_CYCLES - 1);

  busy_e           state;
  logic [CNT_W-1:0] cnt;

  assign wip        = (state != BUSY_NONE);
  assign wrr_commit = (state == BUSY_WRR) && (cnt == '0);
  assign pgm_end    = (state == BUSY_PGM) && pgm_done;
  assign ers_end    = (state == BUSY_ERS) && ers_done;
  assign op_end     = wrr_commit || pgm_end || ers_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= BUSY_NONE;
      cnt   <= '0;
    end else begin
      case (state)
        BUSY_NONE: begin
          if (act == ACT_WRR_GO) begin
            state <= BUSY_WRR;
            cnt   <= CNT_LOAD;
          end else if (act == ACT_PGM_GO) begin
            state <= BUSY_PGM;
          end else if (act == ACT_ERS_GO) begin
            state <= BUSY_ERS;
          end
        end
        BUSY_WRR: begin
          if (cnt == '0) state <= BUSY_NONE;
          else           cnt   <= cnt - 1'b1;
        end
        BUSY_PGM: if (pgm_done) state <= BUSY_NONE;
        BUSY_ERS: if (ers_done) state <= BUSY_NONE;
        default:  state <= BUSY_NONE;
      endcase
    end
  end
endmodule

// File: rtl/fsr_nv_reg.sv
module fsr_nv_reg #(
  parameter logic [7:0] INIT = 8'h00,
  parameter logic [7:0] MASK = 8'h9C
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       load,
  input  logic [7:0] d,
  output logic [7:0] q
);
  // bits outside MASK stay at zero for ever
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    q <= INIT & MASK;
    else if (load) q <= d & MASK;
  end
endmodule

// File: rtl/flash_status_ctrl.sv
module flash_status_ctrl
  import fsr_pkg::*;
#(
  parameter int         WRR_CYCLES = 4,
  parameter logic [7:0] NV_DEFAULT = 8'h00
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_op,
  input  logic [7:0] cmd_wdata,
  input  logic       wp_n,
  input  logic       pgm_req,
  input  logic       ers_req,
  input  logic       ers_bulk,
  input  logic       sect_prot,
  input  logic       pgm_done,
  input  logic       ers_done,
  input  logic       op_fail,
  output logic [7:0] status,
  output logic       wr_enabled,
  output logic       wrr_accept,
  output logic       wrr_reject,
  output logic       pgm_accept,
  output logic       pgm_reject,
  output logic       ers_accept,
  output logic       ers_reject
);
  logic       vrst_n;
  logic       wip, wrr_commit, op_end, pgm_end, ers_end;
  logic       wel, perr, eerr;
  logic [7:0] nv_q, pend;
  act_e       act;

  assign vrst_n = rst_n && por_n;

  fsr_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .pgm_req   (pgm_req),
    .ers_req   (ers_req),
    .ers_bulk  (ers_bulk),
    .sect_prot (sect_prot),
    .wip       (wip),
    .wel       (wel),
    .lock      (nv_q[B_LOCK]),
    .wp_n      (wp_n),
    .act       (act)
  );

  fsr_busy_ctrl #(.WRR_CYCLES(WRR_CYCLES)) u_busy (
    .clk        (clk),
    .rst_n      (vrst_n),
    .act        (act),
    .pgm_done   (pgm_done),
    .ers_done   (ers_done),
    .wip        (wip),
    .wrr_commit (wrr_commit),
    .op_end     (op_end),
    .pgm_end    (pgm_end),
    .ers_end    (ers_end)
  );

  fsr_nv_reg #(.INIT(NV_DEFAULT), .MASK(NV_MASK)) u_nv (
    .clk   (clk),
    .por_n (por_n),
    .load  (wrr_commit),
    .d     (pend),
    .q     (nv_q)
  );

  // pending write-registers data, held while busy
  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n)                pend <= '0;
    else if (act == ACT_WRR_GO) pend <= cmd_wdata;
  end

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      wel <= 1'b0;
    end else begin
      case (act)
        ACT_WREN:           wel <= 1'b1;
        ACT_WRDI, ACT_CLSR: wel <= 1'b0;
        default:            if (op_end) wel <= 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      perr <= 1'b0;
      eerr <= 1'b0;
    end else if (act == ACT_CLSR) begin
      perr <= 1'b0;
      eerr <= 1'b0;
    end else begin
      if (act == ACT_PGM_PROT || (pgm_end && op_fail)) perr <= 1'b1;
      if (act == ACT_ERS_PROT || (ers_end && op_fail)) eerr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge vrst_n) begin
    if (!vrst_n) begin
      wrr_accept <= 1'b0;
      wrr_reject <= 1'b0;
      pgm_accept <= 1'b0;
      pgm_reject <= 1'b0;
      ers_accept <= 1'b0;
      ers_reject <= 1'b0;
    end else begin
      wrr_accept <= (act == ACT_WRR_GO);
      wrr_reject <= (act == ACT_WRR_REJ);
      pgm_accept <= (act == ACT_PGM_GO);
      pgm_reject <= (act == ACT_PGM_REJ) || (act == ACT_PGM_PROT);
      ers_accept <= (act == ACT_ERS_GO);
      ers_reject <= (act == ACT_ERS_REJ) || (act == ACT_ERS_PROT);
    end
  end

  always_comb begin
    status         = nv_q;
    status[B_PERR] = perr;
    status[B_EERR] = eerr;
    status[B_WEL]  = wel;
    status[B_WIP]  = wip;
  end

  assign wr_enabled = wel;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
  import fsr_pkg::*;
(
  input logic       clk,
  input logic       por_n,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_op,
  input logic       wp_n,
  input logic       pgm_req,
  input logic       ers_req,
  input logic       ers_bulk,
  input logic [7:0] status,
  input logic       wrr_accept,
  input logic       wrr_reject,
  input logic       pgm_accept,
  input logic       pgm_reject,
  input logic       ers_accept,
  input logic       ers_reject
);
  logic any_acc, any_flag;
  assign any_acc  = wrr_accept || pgm_accept || ers_accept;
  assign any_flag = any_acc || wrr_reject || pgm_reject || ers_reject;

  AST_WRR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!status[0] && cmd_valid && cmd_op == OP_WRR && status[7] && !wp_n)
    |=> (wrr_reject && $stable(status[7]) && $stable(status[4:2]))); // R3

  AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (status[6] && !(cmd_valid && cmd_op == OP_CLSR && !status[0])) |=> status[6]); // R4

  AST_BULK_CLEAN: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!status[0] && status[1] && !status[5] && !cmd_valid && !pgm_req && ers_req && ers_bulk)
    |=> (!status[5] && ers_accept)); // R5

  AST_WEL_RISE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $rose(status[1]) |-> $past(cmd_valid && cmd_op == OP_WREN)); // R6

  AST_WEL_GATE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    (!status[0] && !status[1]) |=> !any_acc); // R7

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    $onehot0({wrr_accept, wrr_reject, pgm_accept, pgm_reject, ers_accept, ers_reject})); // R7

  AST_ACC_BUSY: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    any_acc |-> status[0]); // R8

  AST_BUSY_MUTE: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
    status[0] |=> !any_flag); // R9
endmodule

bind flash_status_ctrl fsr_checker u_chk (
  .clk        (clk),
  .por_n      (por_n),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .wp_n       (wp_n),
  .pgm_req    (pgm_req),
  .ers_req    (ers_req),
  .ers_bulk   (ers_bulk),
  .status     (status),
  .wrr_accept (wrr_accept),
  .wrr_reject (wrr_reject),
  .pgm_accept (pgm_accept),
  .pgm_reject (pgm_reject),
  .ers_accept (ers_accept),
  .ers_reject (ers_reject)
);

// File: tb/sim_flash_status_ctrl.sv
module sim_flash_status_ctrl;
  localparam int WRRC = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       por_n = 1'b0, rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_op = '0, cmd_wdata = '0;
  logic       wp_n = 1'b1, pgm_req = 1'b0, ers_req = 1'b0, ers_bulk = 1'b0;
  logic       sect_prot = 1'b0, pgm_done = 1'b0, ers_done = 1'b0, op_fail = 1'b0;
  logic [7:0] status;
  logic       wr_enabled, wrr_accept, wrr_reject, pgm_accept, pgm_reject, ers_accept, ers_reject;

  flash_status_ctrl #(.WRR_CYCLES(WRRC), .NV_DEFAULT(8'h00)) u0 (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_wdata(cmd_wdata), .wp_n(wp_n), .pgm_req(pgm_req), .ers_req(ers_req),
    .ers_bulk(ers_bulk), .sect_prot(sect_prot), .pgm_done(pgm_done), .ers_done(ers_done),
    .op_fail(op_fail), .status(status), .wr_enabled(wr_enabled), .wrr_accept(wrr_accept),
    .wrr_reject(wrr_reject), .pgm_accept(pgm_accept), .pgm_reject(pgm_reject),
    .ers_accept(ers_accept), .ers_reject(ers_reject));

  int checks = 0, fails = 0;

  // expected-state model, built from the requirements
  logic [7:0] m_nv = '0, m_pend = '0;
  logic       m_perr = 0, m_eerr = 0, m_wel = 0;
  int         m_busy = 0, m_cnt = 0;   // 0 idle, 1 wrr, 2 pgm, 3 erase
  logic [5:0] m_fl = '0;               // wrr acc/rej, pgm acc/rej, ers acc/rej

  function automatic logic [7:0] exp_status();
    return m_nv | {1'b0, m_perr, m_eerr, 3'b000, m_wel, (m_busy != 0)};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [5:0] fl = '0;
    if (!por_n) begin
      m_nv = '0; m_pend = '0; m_perr = 0; m_eerr = 0; m_wel = 0; m_busy = 0; m_cnt = 0;
    end else if (!rst_n) begin
      m_perr = 0; m_eerr = 0; m_wel = 0; m_busy = 0; m_cnt = 0;
    end else if (m_busy == 1) begin                       // R8
      if (m_cnt == 0) begin m_nv = m_pend & 8'h9C; m_wel = 0; m_busy = 0; end
      else m_cnt--;
    end else if (m_busy == 2) begin
      if (pgm_done) begin m_perr |= op_fail; m_wel = 0; m_busy = 0; end
    end else if (m_busy == 3) begin
      if (ers_done) begin m_eerr |= op_fail; m_wel = 0; m_busy = 0; end
    end else if (cmd_valid) begin                         // R12 priority
      case (cmd_op)
        8'h06: m_wel = 1;
        8'h04: m_wel = 0;
        8'h30: begin m_perr = 0; m_eerr = 0; m_wel = 0; end
        8'h01: begin
          if (!m_wel || (m_nv[7] && !wp_n)) fl[4] = 1;
          else begin fl[5] = 1; m_pend = cmd_wdata; m_busy = 1; m_cnt = WRRC - 1; end
        end
        default: ;
      endcase
    end else if (pgm_req) begin
      if (!m_wel) fl[2] = 1;
      else if (sect_prot) begin fl[2] = 1; m_perr = 1; end
      else begin fl[3] = 1; m_busy = 2; end
    end else if (ers_req) begin
      if (!m_wel) fl[0] = 1;
      else if (sect_prot && !ers_bulk) begin fl[0] = 1; m_eerr = 1; end
      else begin fl[1] = 1; m_busy = 3; end
    end
    m_fl = fl;
  endtask

  // one clock: model, edge, compare at falling edge, drop strobes
  task automatic cycle();
    logic [7:0] e;
    model_step();
    @(posedge clk);
    @(negedge clk);
    e = exp_status();
    chk("R3 lock/protect bits", {status[7], 3'b0, status[4:2], 1'b0}, {e[7], 3'b0, e[4:2], 1'b0});
    chk("R4 program error",     {7'b0, status[6]}, {7'b0, e[6]});
    chk("R5 erase error",       {7'b0, status[5]}, {7'b0, e[5]});
    chk("R6 write-enable",      {6'b0, status[1], wr_enabled}, {6'b0, e[1], e[1]});
    chk("R8 busy",              {7'b0, status[0]}, {7'b0, e[0]});
    chk("R7 flags", {2'b0, wrr_accept, wrr_reject, pgm_accept, pgm_reject, ers_accept, ers_reject},
        {2'b0, m_fl});
    cmd_valid = 0; pgm_req = 0; ers_req = 0; pgm_done = 0; ers_done = 0;
  endtask

  task automatic cmd(input logic [7:0] op, input logic [7:0] d);
    cmd_valid = 1; cmd_op = op; cmd_wdata = d; cycle();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    @(negedge clk);
    idle(2);
    por_n = 1; rst_n = 1;
    idle(1);
    chk("R1 reset value", status, 8'h00);

    cmd(8'h06, 0);  chk("R2 wren", status, 8'h02);
    cmd(8'h05, 0);  chk("R2 read has no effect", status, 8'h02);
    cmd(8'hAA, 0);  chk("R2 unknown opcode ignored", status, 8'h02);

    cmd(8'h01, 8'hFF);
    chk("R7 wrr accepted", {7'b0, wrr_accept}, 8'h01);
    chk("R8 busy set", status, 8'h03);
    cmd(8'h04, 0);  chk("R9 wrdi ignored while busy", status, 8'h03);
    idle(1);        chk("R8 still busy", status, 8'h03);
    idle(1);        chk("R6 commit keeps read-only bits", status, 8'h9C);

    rst_n = 0; cycle(); rst_n = 1;
    chk("R11 reset keeps nv bits", status, 8'h9C);

    cmd(8'h06, 0);
    wp_n = 0; cmd(8'h01, 8'h00);
    chk("R3 locked write rejected", {7'b0, wrr_reject}, 8'h01);
    chk("R3 bits unchanged", status, 8'h9E);
    wp_n = 1; cmd(8'h01, 8'h00);
    idle(WRRC);     chk("R3 write with pin high", status, 8'h00);

    cmd(8'h06, 0);
    sect_prot = 1; ers_req = 1; ers_bulk = 0; cycle();
    chk("R5 protected sector erase", status, 8'h22);
    ers_req = 1; ers_bulk = 1; cycle();
    chk("R5 bulk erase accepted", {7'b0, ers_accept}, 8'h01);
    chk("R5 bulk erase no error", status, 8'h23);
    ers_done = 1; op_fail = 0; cycle(); sect_prot = 0; ers_bulk = 0;
    chk("R6 clears on completion", status, 8'h20);
    cmd(8'h30, 0);  chk("R10 clear status", status, 8'h00);

    cmd(8'h06, 0);
    sect_prot = 1; pgm_req = 1; cycle(); sect_prot = 0;
    chk("R4 protected program", status, 8'h42);
    pgm_req = 1; cycle();
    pgm_done = 1; op_fail = 1; cycle(); op_fail = 0;
    chk("R4 program failure", status, 8'h40);
    cmd(8'h06, 0);
    cmd(8'h30, 0);  chk("R10 clear drops wel", status, 8'h00);

    pgm_req = 1; cycle();
    chk("R7 no wel reject", {7'b0, pgm_reject}, 8'h01);
    chk("R7 no state change", status, 8'h00);

    pgm_req = 1; cmd(8'h06, 0);
    chk("R12 command wins", {6'b0, pgm_accept, pgm_reject}, 8'h00);
    chk("R12 command applied", status, 8'h02);

    por_n = 0; cycle(); por_n = 1;
    chk("R11 power-on clears", status, 8'h00);

    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      wp_n      = ($urandom_range(0, 3) != 0);
      sect_prot = ($urandom_range(0, 3) == 0);
      ers_bulk  = $urandom_range(0, 1);
      op_fail   = ($urandom_range(0, 3) == 0);
      pgm_done  = ($urandom_range(0, 5) == 0);
      ers_done  = ($urandom_range(0, 5) == 0);
      pgm_req   = ($urandom_range(0, 9) == 0);
      ers_req   = ($urandom_range(0, 9) == 0);
      if (r < 40) begin
        cmd_valid = 1;
        cmd_wdata = 8'($urandom);
        case ($urandom_range(0, 5))
          0: cmd_op = 8'h05;
          1: cmd_op = 8'h01;
          2: cmd_op = 8'h06;
          3: cmd_op = 8'h04;
          4: cmd_op = 8'h30;
          default: cmd_op = 8'($urandom);
        endcase
      end
      if (r == 98) rst_n = 0;
      if (r == 99) por_n = 0;
      cycle();
      rst_n = 1; por_n = 1;
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule